// File: doc/BRIEF.md
# Operand Bypass Select

This block decides, for every source operand still waiting to be read in a five-stage in-order integer pipeline, whether the operand value must be taken from a younger result instead of the register file. Results in flight sit in the memory stage and the write-back stage. The block compares each pending source register index against both destination indices and emits a small select code that steers an operand multiplexer outside the block.

Two consumer stages are served at once. The execute stage needs both of its operands for arithmetic. The decode stage needs both of its operands too, because branch and jump targets and conditions are resolved there. Each of the four operands gets its own select, and all four follow one rule. The younger producer (memory stage) wins over the older one (write-back stage). A producer whose destination is register zero, or whose write enable is low, is never a source. The block holds no state and adds no latency. Its selects follow its inputs within the same cycle.

Top module: `operand_bypass_select`

## Requirements
- R1: A select reads 01 (take from memory stage) whenever the memory-stage write enable is 1, the memory-stage destination index is nonzero, and that index equals the operand's source index.
- R2: When the R1 condition is false for an operand, its select reads 10 (take from write-back stage) if the write-back write enable is 1, the write-back destination index is nonzero, and that index equals the operand's source index.
- R3: When both producers qualify for the same operand, the select reads 01; the memory stage always has priority.
- R4: A destination index of zero never yields 01 or 10, even with its write enable set, and a source index of zero always reads 00.
- R5: A producer whose write enable is 0 never causes forwarding; with both enables at 0 every select reads 00.
- R6: The four selects (execute rs1, execute rs2, decode rs1, decode rs2) are each decided on their own source index alone, so different operands may show different codes in the same cycle.
- R7: The code 11 is never produced; 00 means read the register file, and any consumer treats 11 as 00.
- R8: The block is purely combinational: a select settles in the same cycle its inputs change, with no clock and no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1_idx | input | IDX_W | First source index of the instruction in execute |
| ex_rs2_idx | input | IDX_W | Second source index of the instruction in execute |
| id_rs1_idx | input | IDX_W | First source index of the instruction in decode |
| id_rs2_idx | input | IDX_W | Second source index of the instruction in decode |
| mem_rd_idx | input | IDX_W | Destination index of the instruction in the memory stage |
| mem_wr_en | input | 1 | Register write enable of the memory-stage instruction |
| wb_rd_idx | input | IDX_W | Destination index of the instruction in write-back |
| wb_wr_en | input | 1 | Register write enable of the write-back instruction |
| ex_rs1_sel | output | 2 | Bypass select for execute rs1 |
| ex_rs2_sel | output | 2 | Bypass select for execute rs2 |
| id_rs1_sel | output | 2 | Bypass select for decode rs1 |
| id_rs2_sel | output | 2 | Bypass select for decode rs2 |

## Verification
The checker module re-evaluates all four selects whenever an input changes. It confirms that a memory-stage or write-back code only appears with a qualifying producer, that a qualifying memory stage always wins, that zero indices and cleared enables give 00, and that 11 never shows. Only the bench's scenarios can show independence between operands, the write-back choice when the memory stage matches but is disabled, and exact codes across a sweep of index patterns. These scenarios use a reference model written from the requirements.

// File: rtl/byp_pkg.sv
// Package: byp_pkg
// Shared select encoding and structural counts for the operand bypass
// select block. Assumes a register file whose index zero is hard-wired.
package byp_pkg;

    // Two-bit bypass select; 2'b11 is never driven.
    typedef enum logic [1:0] {
        BYP_NONE = 2'b00,
        BYP_MEM  = 2'b01,
        BYP_WB   = 2'b10
    } byp_sel_e;

    // Source operands per consuming stage.
    localparam int NUM_SRC  = 2;
    // Consuming stages: index 0 is execute, index 1 is decode.
    localparam int NUM_CONS = 2;
    // Width of one select code.
    localparam int SEL_W    = 2;

endpackage

// File: rtl/byp_match.sv
// Module: byp_match
// Compares one producer stage's destination against one source index.
// Asserts hit only when the producer writes and its destination is a
// register other than index zero. Purely combinational.
module byp_match #(
    parameter int IDX_W = 5
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] src_idx,
    output logic             hit
);

    logic dst_live;
    logic idx_equal;

    // Destination qualifies only if it is written and is not register zero.
    always_comb begin
        dst_live  = wr_en & (|dst_idx);
        idx_equal = (dst_idx == src_idx);
        hit       = dst_live & idx_equal;
    end

endmodule

// File: rtl/byp_lane.sv
// Module: byp_lane
// Produces the select for one source operand from the memory-stage and
// write-back comparisons, giving the memory stage priority.
// Assumes the memory stage holds the younger of the two results.
module byp_lane #(
    parameter int IDX_W = 5
) (
    input  logic                     mem_wr_en,
    input  logic [IDX_W-1:0]         mem_rd_idx,
    input  logic                     wb_wr_en,
    input  logic [IDX_W-1:0]         wb_rd_idx,
    input  logic [IDX_W-1:0]         src_idx,
    output logic [byp_pkg::SEL_W-1:0] sel
);
    import byp_pkg::*;

    logic mem_hit;
    logic wb_hit;

    byp_match #(.IDX_W(IDX_W)) u_mem_match (
        .wr_en   (mem_wr_en),
        .dst_idx (mem_rd_idx),
        .src_idx (src_idx),
        .hit     (mem_hit)
    );

    byp_match #(.IDX_W(IDX_W)) u_wb_match (
        .wr_en   (wb_wr_en),
        .dst_idx (wb_rd_idx),
        .src_idx (src_idx),
        .hit     (wb_hit)
    );

    // Priority pick: younger producer first, then older, else register file.
    always_comb begin
        if (mem_hit) begin
            sel = BYP_MEM;
        end else if (wb_hit) begin
            sel = BYP_WB;
        end else begin
            sel = BYP_NONE;
        end
    end

endmodule

// File: rtl/byp_stage.sv
// Module: byp_stage
// Holds one lane per source operand of a consuming stage. Every lane sees
// the same producer information and only its own source index.
module byp_stage #(
    parameter int IDX_W   = 5,
    parameter int NSRC    = byp_pkg::NUM_SRC
) (
    input  logic                                 mem_wr_en,
    input  logic [IDX_W-1:0]                     mem_rd_idx,
    input  logic                                 wb_wr_en,
    input  logic [IDX_W-1:0]                     wb_rd_idx,
    input  logic [NSRC-1:0][IDX_W-1:0]           src_idx,
    output logic [NSRC-1:0][byp_pkg::SEL_W-1:0]  sel
);

    // One independent lane per operand.
    for (genvar s = 0; s < NSRC; s++) begin : g_lane
        byp_lane #(.IDX_W(IDX_W)) u_lane (
            .mem_wr_en  (mem_wr_en),
            .mem_rd_idx (mem_rd_idx),
            .wb_wr_en   (wb_wr_en),
            .wb_rd_idx  (wb_rd_idx),
            .src_idx    (src_idx[s]),
            .sel        (sel[s])
        );
    end

endmodule

// File: rtl/operand_bypass_select.sv
// Module: operand_bypass_select
// Top of the bypass select block. Serves the execute stage and the decode
// stage (where branches resolve) with one select per source operand.
// Assumes in-order retirement: memory stage younger than write-back.
// No clock and no reset: outputs follow inputs combinationally.
module operand_bypass_select #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] ex_rs1_idx,
    input  logic [IDX_W-1:0] ex_rs2_idx,
    input  logic [IDX_W-1:0] id_rs1_idx,
    input  logic [IDX_W-1:0] id_rs2_idx,
    input  logic [IDX_W-1:0] mem_rd_idx,
    input  logic             mem_wr_en,
    input  logic [IDX_W-1:0] wb_rd_idx,
    input  logic             wb_wr_en,
    output logic [1:0]       ex_rs1_sel,
    output logic [1:0]       ex_rs2_sel,
    output logic [1:0]       id_rs1_sel,
    output logic [1:0]       id_rs2_sel
);
    import byp_pkg::*;

    localparam int CONS_EX = 0;
    localparam int CONS_ID = 1;

    logic [NUM_CONS-1:0][NUM_SRC-1:0][IDX_W-1:0] cons_src;
    logic [NUM_CONS-1:0][NUM_SRC-1:0][SEL_W-1:0] cons_sel;

    // Gather the source indices per consuming stage.
    always_comb begin
        cons_src[CONS_EX][0] = ex_rs1_idx;
        cons_src[CONS_EX][1] = ex_rs2_idx;
        cons_src[CONS_ID][0] = id_rs1_idx;
        cons_src[CONS_ID][1] = id_rs2_idx;
    end

    // One stage block per consumer; all share the producer view.
    for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
        byp_stage #(.IDX_W(IDX_W), .NSRC(NUM_SRC)) u_stage (
            .mem_wr_en  (mem_wr_en),
            .mem_rd_idx (mem_rd_idx),
            .wb_wr_en   (wb_wr_en),
            .wb_rd_idx  (wb_rd_idx),
            .src_idx    (cons_src[c]),
            .sel        (cons_sel[c])
        );
    end

    // Scatter the selects to the named outputs.
    always_comb begin
        ex_rs1_sel = cons_sel[CONS_EX][0];
        ex_rs2_sel = cons_sel[CONS_EX][1];
        id_rs1_sel = cons_sel[CONS_ID][0];
        id_rs2_sel = cons_sel[CONS_ID][1];
    end

endmodule

// File: rtl/byp_select_checker.sv
// Module: byp_select_checker
// Property checks on the bypass select outputs, evaluated whenever any
// port changes. Bound to operand_bypass_select below.
module byp_select_checker #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] ex_rs1_idx,
    input  logic [IDX_W-1:0] ex_rs2_idx,
    input  logic [IDX_W-1:0] id_rs1_idx,
    input  logic [IDX_W-1:0] id_rs2_idx,
    input  logic [IDX_W-1:0] mem_rd_idx,
    input  logic             mem_wr_en,
    input  logic [IDX_W-1:0] wb_rd_idx,
    input  logic             wb_wr_en,
    input  logic [1:0]       ex_rs1_sel,
    input  logic [1:0]       ex_rs2_sel,
    input  logic [1:0]       id_rs1_sel,
    input  logic [1:0]       id_rs2_sel
);

    logic [IDX_W-1:0] chk_src [4];
    logic [1:0]       chk_sel [4];

    // Line up each operand with its select for the per-lane checks.
    always_comb begin
        chk_src[0] = ex_rs1_idx;  chk_sel[0] = ex_rs1_sel;
        chk_src[1] = ex_rs2_idx;  chk_sel[1] = ex_rs2_sel;
        chk_src[2] = id_rs1_idx;  chk_sel[2] = id_rs1_sel;
        chk_src[3] = id_rs2_idx;  chk_sel[3] = id_rs2_sel;
    end

    for (genvar g = 0; g < 4; g++) begin : g_chk
        // Per-lane properties on the settled select.
        always_comb begin
            p_no_code3_r7: assert (chk_sel[g] != 2'b11)
                else $error("lane %0d drove code 11", g);

            if (chk_sel[g] == 2'b01) begin
                p_mem_qualified_r1: assert (mem_wr_en && (mem_rd_idx == chk_src[g]) && (mem_rd_idx != '0))
                    else $error("lane %0d chose memory stage without a qualifying producer", g);
            end

            if (chk_sel[g] == 2'b10) begin
                p_wb_qualified_r2: assert (wb_wr_en && (wb_rd_idx == chk_src[g]) && (wb_rd_idx != '0))
                    else $error("lane %0d chose write-back without a qualifying producer", g);
                p_wb_not_over_mem_r3: assert (!(mem_wr_en && (mem_rd_idx == chk_src[g]) && (mem_rd_idx != '0)))
                    else $error("lane %0d chose write-back over a qualifying memory stage", g);
            end

            if (chk_src[g] == '0) begin
                p_zero_src_r4: assert (chk_sel[g] == 2'b00)
                    else $error("lane %0d forwarded for register zero", g);
            end

            if (!mem_wr_en && !wb_wr_en) begin
                p_no_enable_r5: assert (chk_sel[g] == 2'b00)
                    else $error("lane %0d forwarded with both enables low", g);
            end
        end
    end

endmodule

bind operand_bypass_select byp_select_checker #(.IDX_W(IDX_W)) u_byp_chk (
    .ex_rs1_idx (ex_rs1_idx),
    .ex_rs2_idx (ex_rs2_idx),
    .id_rs1_idx (id_rs1_idx),
    .id_rs2_idx (id_rs2_idx),
    .mem_rd_idx (mem_rd_idx),
    .mem_wr_en  (mem_wr_en),
    .wb_rd_idx  (wb_rd_idx),
    .wb_wr_en   (wb_wr_en),
    .ex_rs1_sel (ex_rs1_sel),
    .ex_rs2_sel (ex_rs2_sel),
    .id_rs1_sel (id_rs1_sel),
    .id_rs2_sel (id_rs2_sel)
);

// File: tb/tb_operand_bypass_select.sv
// Scoreboard bench: a driver task applies a vector and queues the expected
// selects; a monitor at the falling edge pops and compares.
module tb_operand_bypass_select;

    localparam int IDX_W = 5;
    localparam int WATCHDOG_CYC = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [IDX_W-1:0] ex_rs1_idx, ex_rs2_idx, id_rs1_idx, id_rs2_idx;
    logic [IDX_W-1:0] mem_rd_idx, wb_rd_idx;
    logic             mem_wr_en, wb_wr_en;
    logic [1:0]       ex_rs1_sel, ex_rs2_sel, id_rs1_sel, id_rs2_sel;

    operand_bypass_select #(.IDX_W(IDX_W)) dut (
        .ex_rs1_idx (ex_rs1_idx),
        .ex_rs2_idx (ex_rs2_idx),
        .id_rs1_idx (id_rs1_idx),
        .id_rs2_idx (id_rs2_idx),
        .mem_rd_idx (mem_rd_idx),
        .mem_wr_en  (mem_wr_en),
        .wb_rd_idx  (wb_rd_idx),
        .wb_wr_en   (wb_wr_en),
        .ex_rs1_sel (ex_rs1_sel),
        .ex_rs2_sel (ex_rs2_sel),
        .id_rs1_sel (id_rs1_sel),
        .id_rs2_sel (id_rs2_sel)
    );

    typedef struct {
        logic [7:0] exp_sel;   // {id_rs2, id_rs1, ex_rs2, ex_rs1}
        string      req;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference: memory stage first, then write-back, else register file.
    function automatic logic [1:0] ref_sel(input logic [IDX_W-1:0] src,
                                           input logic mwe, input logic [IDX_W-1:0] mrd,
                                           input logic wwe, input logic [IDX_W-1:0] wrd);
        if (mwe && mrd != 0 && mrd == src) return 2'b01;
        if (wwe && wrd != 0 && wrd == src) return 2'b10;
        return 2'b00;
    endfunction

    // Driver: apply one vector after a rising edge and queue its expectation.
    task automatic drive(input logic [IDX_W-1:0] e1, input logic [IDX_W-1:0] e2,
                         input logic [IDX_W-1:0] i1, input logic [IDX_W-1:0] i2,
                         input logic mwe, input logic [IDX_W-1:0] mrd,
                         input logic wwe, input logic [IDX_W-1:0] wrd,
                         input string req);
        sb_item_t it;
        @(posedge clk);
        #1;
        {ex_rs1_idx, ex_rs2_idx, id_rs1_idx, id_rs2_idx, mem_wr_en, mem_rd_idx, wb_wr_en, wb_rd_idx}
            = {e1, e2, i1, i2, mwe, mrd, wwe, wrd};
        it.exp_sel = {ref_sel(i2, mwe, mrd, wwe, wrd), ref_sel(i1, mwe, mrd, wwe, wrd),
                      ref_sel(e2, mwe, mrd, wwe, wrd), ref_sel(e1, mwe, mrd, wwe, wrd)};
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare the settled selects once per cycle, away from the edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = {id_rs2_sel, id_rs1_sel, ex_rs2_sel, ex_rs1_sel};
            n_vec++;
            if (act !== it.exp_sel) begin
                n_fail++;
                $display("FAIL %s: selects {id2,id1,ex2,ex1} actual=%b expected=%b",
                         it.req, act, it.exp_sel);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        {ex_rs1_idx, ex_rs2_idx, id_rs1_idx, id_rs2_idx, mem_wr_en, mem_rd_idx, wb_wr_en, wb_rd_idx} = '0;
        // Reset state: all-zero inputs give no forwarding (R5, R7).
        drive(0, 0, 0, 0, 1'b0, 0, 1'b0, 0, "R5 reset state");
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: memory-stage match on execute rs1 only; same-cycle result (R8).
        drive(5, 6, 7, 8, 1'b1, 5, 1'b0, 0, "R1 mem match ex rs1");
        // R2: write-back match on decode rs2.
        drive(1, 2, 3, 9, 1'b0, 0, 1'b1, 9, "R2 wb match id rs2");
        // R3: both producers on index 7 across all operands.
        drive(7, 7, 7, 7, 1'b1, 7, 1'b1, 7, "R3 mem over wb");
        // R4: zero destinations with enables high, zero sources.
        drive(0, 0, 0, 0, 1'b1, 0, 1'b1, 0, "R4 x0 never forwards");
        // R4: zero source against nonzero producers.
        drive(0, 4, 0, 4, 1'b1, 4, 1'b1, 3, "R4 x0 source");
        // R5: matching indices but both enables low.
        drive(12, 13, 12, 13, 1'b0, 12, 1'b0, 13, "R5 enables low");
        // R2/R5: memory matches but disabled, write-back takes over.
        drive(10, 11, 10, 11, 1'b0, 10, 1'b1, 10, "R2 disabled mem falls to wb");
        // R6: four operands, mixed outcomes in one cycle.
        drive(3, 4, 4, 3, 1'b1, 3, 1'b1, 4, "R6 independent lanes");
        // R6: decode only matches while execute misses.
        drive(20, 21, 22, 23, 1'b1, 22, 1'b1, 23, "R6 decode lanes only");
        // R7: full sweep of both destinations per index.
        for (int k = 0; k < 32; k++) begin
            drive(k[4:0], k[4:0] ^ 5'd1, k[4:0], 5'd31 - k[4:0], 1'b1, k[4:0], 1'b1, k[4:0] ^ 5'd1,
                  "R7 index sweep");
        end
        // R8: pseudo-random patterns over small index sets to provoke matches.
        lfsr = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive({3'b0, lfsr[1:0]}, {3'b0, lfsr[3:2]}, {3'b0, lfsr[5:4]}, {3'b0, lfsr[7:6]},
                  lfsr[8], {3'b0, lfsr[10:9]}, lfsr[11], {3'b0, lfsr[13:12]}, "R8 random");
        end

        // Let the monitor drain the queue.
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule